// File: doc/BRIEF.md
# Bit-packed posting block decoder

This block unpacks one compressed block of an inverted-index posting list. The block holds (document-number gap, term-frequency) pairs, and each field is stored with the fewest bits its block needs. A scheduler hands the decoder the block's first document number and a 64-bit descriptor word. The decoder then pulls 512-bit chunks of packed bits through a fetch port, one chunk index at a time. It emits one decoded posting per cycle on a valid/ready stream: an absolute 32-bit document number and a 32-bit frequency. A last flag marks the final posting of the block.

The field widths can change from one block to the next, and a pair may sit across the seam between two chunks. To cover this, the decoder keeps a two-chunk window and a bit pointer. It stalls only when a pair reaches into a chunk that has not yet arrived. Document numbers are rebuilt by adding each gap to the previous number, starting from the block's first document number.

Top module: `posting_block_decoder`

## Requirements
- R1: After reset, out_valid is 0, fetch_req is 0 and sched_ready is 1.
- R2: A descriptor is taken when sched_valid and sched_ready are both 1, and sched_ready is 1 only while no block is being decoded. The descriptor fields are: bits [4:0] gap width, bits [9:5] frequency width, bits [20:10] element count, and bits [63:21] a location field that the decoder does not use.
- R3: Packed bits form one stream. Bit j of chunk k is stream bit 512*k+j. Pairs are laid out from stream bit 0 upward, each pair being the gap field, least significant bit first, followed by the frequency field. Chunks are requested with fetch_idx = 0, 1, 2, … and one chunk moves on each cycle where fetch_req and fetch_valid are both 1.
- R4: The first posting of a block outputs the first document number supplied by the scheduler. Its gap bits are consumed and ignored. Each later posting outputs the previous document number plus its gap, modulo 2^32.
- R5: out_tf is the frequency field zero-extended to 32 bits.
- R6: A pair that spans two chunks is decoded correctly. Decoding waits while the chunk holding the rest of a pair is missing. With data present and out_ready held at 1, one posting is produced every cycle.
- R7: A field width of 0 gives a zero field and consumes no bits. When both widths are 0, no chunk is requested.
- R8: Exactly element-count postings are output, and out_last is 1 on the final one only. A block with a count of 0 outputs nothing and leaves sched_ready at 1.
- R9: While out_valid is 1 and out_ready is 0, out_docid, out_tf and out_last hold and no posting is lost.
- R10: Element counts up to 2047 are decoded.
- R11: A block requests exactly ceil(count*(gap width + frequency width)/512) chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_valid | input | 1 | Descriptor offered |
| sched_ready | output | 1 | Decoder idle, descriptor accepted |
| sched_skip | input | 32 | First document number of the block |
| sched_meta | input | 64 | Descriptor word (widths, count, location) |
| fetch_req | output | 1 | Chunk wanted |
| fetch_idx | output | 9 | Index of the chunk wanted, from 0 per block |
| fetch_valid | input | 1 | Chunk data present |
| fetch_data | input | 512 | Chunk data |
| out_valid | output | 1 | Posting valid |
| out_ready | input | 1 | Consumer accepts posting |
| out_docid | output | 32 | Absolute document number |
| out_tf | output | 32 | Zero-extended term frequency |
| out_last | output | 1 | Final posting of the block |

## Verification
A chunk handed over at an edge can feed a pair at the next edge, and a decoded posting appears on the registered outputs one cycle after the pair is extracted. The bench therefore does not predict edge numbers. It records every output and fetch transfer at the falling edge, where that transfer is committed to the coming rising edge. It then compares the recorded sequence with the expected one, and compares the chunk count with the count the widths call for. A separate check applies only where no stall is possible, with chunks answered at once and the output always ready: there the bench expects the first and last posting of the block to be exactly count-1 cycles apart.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int GW_W    = 5;
  localparam int TW_W    = 5;
  localparam int CNT_W   = 11;
  localparam int LOC_W   = 43;
  localparam int META_W  = GW_W + TW_W + CNT_W + LOC_W;
  localparam int DOC_W   = 32;
  localparam int FW_W    = GW_W;
  localparam int PW_W    = FW_W + 1;
  localparam int XW      = 2 * ((1 << FW_W) - 1);

  typedef struct packed {
    logic [LOC_W-1:0] loc;
    logic [CNT_W-1:0] count;
    logic [TW_W-1:0]  tf_w;
    logic [GW_W-1:0]  gap_w;
  } blk_desc_t;
endpackage

// File: rtl/pbd_pair_unpack.sv
module pbd_pair_unpack
  import pbd_pkg::*;
(
  input  logic [XW-1:0]    win,
  input  logic [GW_W-1:0]  gap_w,
  input  logic [TW_W-1:0]  tf_w,
  output logic [DOC_W-1:0] gap,
  output logic [DOC_W-1:0] tf
);
  function automatic logic [XW-1:0] low_mask(input logic [FW_W-1:0] w);
    return (XW'(1) << w) - XW'(1);
  endfunction

  logic [XW-1:0] gap_bits;
  logic [XW-1:0] tf_bits;

  always_comb begin
    gap_bits = win & low_mask(gap_w);
    tf_bits  = (win >> gap_w) & low_mask(tf_w);
    gap      = gap_bits[DOC_W-1:0];
    tf       = tf_bits[DOC_W-1:0];
  end
endmodule

// File: rtl/pbd_chunk_window.sv
module pbd_chunk_window
  import pbd_pkg::*;
#(
  parameter int CHUNK_BITS = 512,
  localparam int PTR_W  = $clog2(CHUNK_BITS),
  localparam int NEED_W = PTR_W + 1,
  localparam int TOT_W  = CNT_W + PW_W,
  localparam int IDX_W  = TOT_W - PTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  en,
  input  logic [CNT_W-1:0]      blk_cnt,
  input  logic [PW_W-1:0]       pair_w,
  input  logic                  consume,
  output logic                  fetch_req,
  output logic [IDX_W-1:0]      fetch_idx,
  input  logic                  fetch_valid,
  input  logic [CHUNK_BITS-1:0] fetch_data,
  output logic                  avail,
  output logic [XW-1:0]         win
);
  logic [CHUNK_BITS-1:0]   lo_q, hi_q;
  logic                    lo_v, hi_v;
  logic [PTR_W-1:0]        ptr_q;
  logic [IDX_W-1:0]        fetched_q;
  logic [TOT_W-1:0]        total_bits;
  logic [TOT_W:0]          total_rnd;
  logic [IDX_W-1:0]        needed;
  logic [NEED_W-1:0]       need;
  logic [2*CHUNK_BITS-1:0] shifted;
  logic                    shift, take, lo_va, hi_va;
  logic [PTR_W-1:0]        ptr_nx;

  always_comb begin
    total_bits = TOT_W'(blk_cnt) * TOT_W'(pair_w);
    total_rnd  = {1'b0, total_bits} + (TOT_W+1)'(CHUNK_BITS - 1);
    needed     = IDX_W'(total_rnd >> PTR_W);
    need       = NEED_W'(ptr_q) + NEED_W'(pair_w);
    avail      = (pair_w == '0) ||
                 (lo_v && ((need <= NEED_W'(CHUNK_BITS)) || hi_v));
    shifted    = {hi_q, lo_q} >> ptr_q;
    win        = shifted[XW-1:0];
    fetch_req  = en && !clear && !hi_v && (fetched_q < needed);
    fetch_idx  = fetched_q;
    take       = fetch_req && fetch_valid;
    shift      = consume && (need >= NEED_W'(CHUNK_BITS));
    ptr_nx     = shift ? PTR_W'(need - NEED_W'(CHUNK_BITS)) : need[PTR_W-1:0];
    lo_va      = shift ? hi_v : lo_v;
    hi_va      = shift ? 1'b0 : hi_v;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lo_v      <= 1'b0;
      hi_v      <= 1'b0;
      ptr_q     <= '0;
      fetched_q <= '0;
    end else begin
      lo_v      <= lo_va || (take && !lo_va);
      hi_v      <= hi_va || (take && lo_va);
      if (consume) ptr_q <= ptr_nx;
      if (take) fetched_q <= fetched_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take && !lo_va) lo_q <= fetch_data;
    else if (shift)     lo_q <= hi_q;
    if (take && lo_va)  hi_q <= fetch_data;
  end
endmodule

// File: rtl/posting_block_decoder.sv
module posting_block_decoder
  import pbd_pkg::*;
#(
  parameter int CHUNK_BITS = 512,
  localparam int PTR_W = $clog2(CHUNK_BITS),
  localparam int IDX_W = CNT_W + PW_W - PTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sched_valid,
  output logic                  sched_ready,
  input  logic [DOC_W-1:0]      sched_skip,
  input  logic [META_W-1:0]     sched_meta,
  output logic                  fetch_req,
  output logic [IDX_W-1:0]      fetch_idx,
  input  logic                  fetch_valid,
  input  logic [CHUNK_BITS-1:0] fetch_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DOC_W-1:0]      out_docid,
  output logic [DOC_W-1:0]      out_tf,
  output logic                  out_last
);
  blk_desc_t        desc;
  logic             active, first_q;
  logic [CNT_W-1:0] blk_cnt, remain_q;
  logic [GW_W-1:0]  blk_gw;
  logic [TW_W-1:0]  blk_tw;
  logic [DOC_W-1:0] prev_q, gap, tf, doc_nx;
  logic [XW-1:0]    win;
  logic [PW_W-1:0]  pair_w;
  logic             accept, avail, fire;

  always_comb begin
    desc        = blk_desc_t'(sched_meta);
    sched_ready = !active;
    accept      = sched_valid && sched_ready;
    pair_w      = PW_W'(blk_gw) + PW_W'(blk_tw);
    fire        = active && avail && (!out_valid || out_ready);
    doc_nx      = first_q ? prev_q : prev_q + gap;
  end

  pbd_chunk_window #(.CHUNK_BITS(CHUNK_BITS)) win_i (
    .clk(clk), .rst(rst), .clear(accept), .en(active),
    .blk_cnt(blk_cnt), .pair_w(pair_w), .consume(fire),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .avail(avail), .win(win)
  );

  pbd_pair_unpack unpack_i (
    .win(win), .gap_w(blk_gw), .tf_w(blk_tw), .gap(gap), .tf(tf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      first_q   <= 1'b0;
      blk_cnt   <= '0;
      remain_q  <= '0;
      blk_gw    <= '0;
      blk_tw    <= '0;
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_docid <= '0;
      out_tf    <= '0;
      out_last  <= 1'b0;
    end else begin
      if (accept) begin
        active   <= (desc.count != '0);
        first_q  <= 1'b1;
        blk_cnt  <= desc.count;
        remain_q <= desc.count;
        blk_gw   <= desc.gap_w;
        blk_tw   <= desc.tf_w;
        prev_q   <= sched_skip;
      end
      if (fire) begin
        out_valid <= 1'b1;
        out_docid <= doc_nx;
        out_tf    <= tf;
        out_last  <= (remain_q == CNT_W'(1));
        prev_q    <= doc_nx;
        first_q   <= 1'b0;
        remain_q  <= remain_q - CNT_W'(1);
        if (remain_q == CNT_W'(1)) active <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
  import pbd_pkg::*;
#(
  parameter int CHUNK_BITS = 512,
  localparam int PTR_W = $clog2(CHUNK_BITS),
  localparam int IDX_W = CNT_W + PW_W - PTR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              sched_valid,
  input logic              sched_ready,
  input logic [META_W-1:0] sched_meta,
  input logic              fetch_req,
  input logic [IDX_W-1:0]  fetch_idx,
  input logic              fetch_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DOC_W-1:0]  out_docid,
  input logic [DOC_W-1:0]  out_tf,
  input logic              out_last
);
  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_docid) &&
                                   $stable(out_tf) && $stable(out_last)));

  // R3
  fetch_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_valid) |=> (fetch_idx == $past(fetch_idx) + IDX_W'(1)));

  // R5
  tf_zext_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tf[DOC_W-1] == 1'b0));

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (sched_valid && sched_ready && (sched_meta[20:10] != 11'd0)) |=> !sched_ready);
endmodule

bind posting_block_decoder pbd_checker #(.CHUNK_BITS(CHUNK_BITS)) chk_i (
  .clk(clk), .rst(rst), .sched_valid(sched_valid), .sched_ready(sched_ready),
  .sched_meta(sched_meta), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
  .fetch_valid(fetch_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_docid(out_docid), .out_tf(out_tf), .out_last(out_last)
);

// File: tb/posting_block_decoder_tb.sv
module posting_block_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int CB    = 512;
  localparam int NCH   = 8;
  localparam int MAXN  = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sched_valid = 1'b0;
  logic sched_ready;
  logic [31:0] sched_skip = '0;
  logic [63:0] sched_meta = '0;
  logic fetch_req;
  logic [8:0] fetch_idx;
  logic fetch_valid = 1'b0;
  logic [CB-1:0] fetch_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_docid, out_tf;
  logic out_last;

  posting_block_decoder #(.CHUNK_BITS(CB)) dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fetch_dly = 0;
  int fetch_wait = 0;
  int fetch_n = 0;
  int ready_mode = 0;
  int got_n = 0;
  logic [NCH*CB-1:0] stream;
  logic [31:0] exp_doc [MAXN];
  logic [31:0] exp_tf  [MAXN];
  logic [31:0] got_doc [MAXN];
  logic [31:0] got_tf  [MAXN];
  logic        got_last[MAXN];
  int          got_cyc [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      fetch_valid = 1'b0;
    end else begin
      if (fetch_req && fetch_wait >= fetch_dly) begin
        fetch_valid = 1'b1;
        fetch_data  = stream[fetch_idx*CB +: CB];
        fetch_wait  = 0;
      end else begin
        fetch_valid = 1'b0;
        if (fetch_req) fetch_wait = fetch_wait + 1;
      end
      if (fetch_req && fetch_valid) fetch_n = fetch_n + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 5 != 1) && (cyc % 7 != 3));
      if (out_valid && out_ready && got_n < MAXN) begin
        got_doc[got_n]  = out_docid;
        got_tf[got_n]   = out_tf;
        got_last[got_n] = out_last;
        got_cyc[got_n]  = cyc;
        got_n = got_n + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] skip, input int gw, input int tw,
                       input int cnt, input logic [31:0] seed);
    int pos = 0;
    stream = '0;
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] v = (i * 32'h9E3779B1) ^ seed;
      logic [31:0] g = v & ((32'd1 << gw) - 1);
      logic [31:0] t = ((v >> 7) ^ (v << 3)) & ((32'd1 << tw) - 1);
      for (int b = 0; b < gw; b++) stream[pos + b] = g[b];
      pos += gw;
      for (int b = 0; b < tw; b++) stream[pos + b] = t[b];
      pos += tw;
      exp_doc[i] = (i == 0) ? skip : exp_doc[i-1] + g;
      exp_tf[i]  = t;
    end
  endtask

  task automatic run_block(input logic [31:0] skip, input int gw, input int tw,
                           input int cnt, input int fdly, input int rmode,
                           input logic [31:0] seed);
    int guard = 0;
    int want_ch;
    build(skip, gw, tw, cnt, seed);
    fetch_dly = fdly;
    ready_mode = rmode;
    @(negedge clk);
    got_n = 0;
    fetch_n = 0;
    sched_skip = skip;
    sched_meta = {43'h1234_5678 ^ 43'(seed), 11'(cnt), 5'(tw), 5'(gw)};
    sched_valid = 1'b1;
    @(negedge clk);
    sched_valid = 1'b0;
    while (got_n < cnt && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
    want_ch = (cnt * (gw + tw) + CB - 1) / CB;
    check(got_n == cnt, "R8 count", got_n, cnt);
    check(fetch_n == want_ch, "R11 chunks", fetch_n, want_ch);
    for (int i = 0; i < cnt && i < got_n; i++) begin
      check(got_doc[i] == exp_doc[i], "R4 docid", got_doc[i], exp_doc[i]);
      check(got_tf[i] == exp_tf[i], "R5 tf", got_tf[i], exp_tf[i]);
      check(got_last[i] == (i == cnt - 1), "R8 last", got_last[i], (i == cnt - 1));
    end
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(fetch_req == 1'b0, "R1 fetch_req", fetch_req, 0);
    check(sched_ready == 1'b1, "R1 sched_ready", sched_ready, 1);
  endtask

  task automatic t_narrow();  // R3 R4 R5
    run_block(32'd1000, 3, 2, 10, 0, 0, 32'h11);
  endtask

  task automatic t_wide_straddle();  // R6 stalls on late chunks
    run_block(32'hFFFF_FF00, 31, 31, 40, 3, 0, 32'h5A5A);
  endtask

  task automatic t_zero_gap();  // R7
    run_block(32'd77, 0, 5, 20, 1, 0, 32'h3);
  endtask

  task automatic t_zero_both();  // R7 no fetch
    run_block(32'd4242, 0, 0, 5, 0, 0, 32'h9);
    check(fetch_n == 0, "R7 no fetch", fetch_n, 0);
  endtask

  task automatic t_backpressure();  // R9
    run_block(32'd5, 7, 9, 64, 2, 1, 32'hBEEF);
  endtask

  task automatic t_boundary_rate();  // R6 one per cycle, pairs on chunk seams
    run_block(32'd0, 16, 16, 32, 0, 0, 32'hC0DE);
    check(got_cyc[31] - got_cyc[0] == 31, "R6 rate", got_cyc[31] - got_cyc[0], 31);
  endtask

  task automatic t_count_zero();  // R8
    @(negedge clk);
    got_n = 0;
    sched_meta = {43'd0, 11'd0, 5'd4, 5'd4};
    sched_valid = 1'b1;
    @(negedge clk);
    sched_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(got_n == 0, "R8 empty block", got_n, 0);
    check(sched_ready == 1'b1, "R8 ready after empty", sched_ready, 1);
  endtask

  task automatic t_max_count();  // R10
    run_block(32'd9, 1, 1, 2047, 0, 1, 32'h77);
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide_straddle();
    t_zero_gap();
    t_zero_both();
    t_backpressure();
    t_boundary_rate();
    t_count_zero();
    t_max_count();
    t_narrow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule